// File: doc/BRIEF.md
# Prescaled Four-Counter Timer Bank

This peripheral sits on a 16-bit processor bus and provides three periodic timers that all run from a common, programmable time base. The first of its four down-counters is not a user timer. It divides the system clock by a programmed value and emits a one-cycle tick. That tick is the only count enable for the other three counters. Software sets one prescaler value to fix the base rate, for example a 100 kHz tick from a 112.5 MHz clock with a value of 1125. It then sets each user timer's period in base ticks.

Each user timer reloads from its own divisor and raises a sticky expiry flag every time it wraps. One shared control word holds the three interrupt enables and the three expiry flags. The interrupt line is a registered level that stays high while any enabled flag is set. Software clears a flag by writing a one to its position in the control word. The bus port is synchronous: chip select, word address, write strobe, 16-bit write data, and read data returned one cycle after the read.

Top module: `tick_timer_bank`

## Requirements
- R1: Word address 7 selects the control word. Word addresses 8, 9, 10 and 11 select the divisors of counters 0, 1, 2 and 3. A read of a divisor returns the last value written to it. A read of any other word address returns zero.
- R2: `bus_rdata` carries the selected word in the cycle after a read (`bus_sel`=1, `bus_wr`=0). It is zero in every cycle that does not follow a read.
- R3: Counter 0 divides the clock by exactly its divisor N. It emits a one-cycle tick every N clock cycles, and a divisor of 1 gives a tick on every cycle.
- R4: Counters 1 to 3 decrement only on a counter-0 tick. Each one expires once every N of those ticks, where N is its own divisor.
- R5: A counter whose divisor is 0 never expires. When counter 0's divisor is 0, counters 1 to 3 never expire either.
- R6: Writing a divisor also reloads that counter. With counter 0 at divisor N written in cycle W and counter 1 at divisor 1, flag 1 sets at clock edge W+N.
- R7: In the control word, bits 1..3 are the interrupt enables of counters 1..3, and bits 9..11 are their expiry flags. All other bits read as zero. A control write loads the enables from bits 1..3.
- R8: An expiry flag sets when its counter expires and stays set until software writes a 1 to its bit. Writing 0 to that bit leaves the flag unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R9: `irq` is registered. In each cycle it equals the OR over counters 1..3 of flag AND enable as they stood in the previous cycle.
- R10: Reset clears all divisors, counters, enables, flags, `bus_rdata` and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Chip select for this peripheral |
| bus_addr | input | 4 | Word address within the peripheral window |
| bus_wr | input | 1 | 1 = write, 0 = read (when selected) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the prescaler's exact period. A counter that divides by N+1 shifts every expiry in the reference model and makes the measured distance from a divisor write to the interrupt one cycle too long. It also clears flags on every cycle while the timers run, so a clear and an expiry land together. A design that lets the clear win then loses flags, which the model detects on the next read. Further stimulus covers divisor zero on the prescaler and on a user timer, writes of zero to flag bits, and reads of unmapped words. A design that counts on a stopped divisor, clears on a written zero, or returns stale data would show a set flag or a nonzero word where the model expects none.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned ADDR_W       = 4;
    localparam int unsigned DATA_W       = 16;
    localparam logic [ADDR_W-1:0] CTL_WORD = 4'd7;
    localparam int unsigned DIV_WORD_BASE = 8;
    localparam int unsigned IEN_LSB      = 1;
    localparam int unsigned FLAG_LSB     = 9;

endpackage

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          cnt_en,
    output logic [DW-1:0] div_o,
    output logic          tc_o
);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [DW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       run;
    logic       at_end;

    always_comb begin
        run    = cnt_en && (st_q.div != '0);
        at_end = (st_q.cnt <= DW'(1));
        tc_o   = run && at_end;
        st_d   = st_q;
        if (load) begin
            st_d.div = load_val;
            st_d.cnt = load_val;
        end else if (tc_o) begin
            st_d.cnt = st_q.div;
        end else if (run) begin
            st_d.cnt = st_q.cnt - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o = st_q.div;

endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned NT = 3,
    parameter int unsigned DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_wr,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NT-1:0]         tc,
    input  logic [NT:0][DW-1:0]   div_all,
    output logic [DW-1:0]         rdata,
    output logic                  irq,
    output logic [NT-1:0]         flag_o,
    output logic [NT-1:0]         ien_o
);

    localparam int unsigned NDIV = NT + 1;

    typedef struct packed {
        logic [NT-1:0] flag;
        logic [NT-1:0] ien;
        logic          irq;
        logic [DW-1:0] rdata;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic [DW-1:0] ctl_word;
    logic [DW-1:0] sel_word;
    logic [NT-1:0] clr_mask;

    always_comb begin
        ctl_word = '0;
        ctl_word[FLAG_LSB +: NT] = st_q.flag;
        ctl_word[IEN_LSB  +: NT] = st_q.ien;

        sel_word = '0;
        if (rd_addr == CTL_WORD) begin
            sel_word = ctl_word;
        end
        for (int i = 0; i < NDIV; i++) begin
            if (int'(rd_addr) == DIV_WORD_BASE + i) begin
                sel_word = div_all[i];
            end
        end

        clr_mask = ctl_wr ? wdata[FLAG_LSB +: NT] : '0;

        st_d       = st_q;
        st_d.flag  = (st_q.flag & ~clr_mask) | tc;
        if (ctl_wr) begin
            st_d.ien = wdata[IEN_LSB +: NT];
        end
        st_d.irq   = |(st_q.flag & st_q.ien);
        st_d.rdata = rd_en ? sel_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.rdata;
    assign irq    = st_q.irq;
    assign flag_o = st_q.flag;
    assign ien_o  = st_q.ien;

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tick_timer_pkg::*;
#(
    parameter int unsigned NUM_CNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq
);

    localparam int unsigned NT = NUM_CNT - 1;
    localparam int unsigned DW = DATA_W;

    logic [NUM_CNT-1:0]         tc_w;
    logic [NUM_CNT-1:0]         en_w;
    logic [NUM_CNT-1:0]         ld_w;
    logic [NUM_CNT-1:0][DW-1:0] div_w;
    logic [NT-1:0]              flag_w;
    logic [NT-1:0]              ien_w;
    logic                       wr_hit;
    logic                       rd_hit;
    logic                       ctl_wr;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;
    assign ctl_wr = wr_hit && (bus_addr == CTL_WORD);

    generate
        for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
            assign ld_w[g] = wr_hit && (int'(bus_addr) == DIV_WORD_BASE + g);
            if (g == 0) begin : g_pre
                assign en_w[g] = 1'b1;
            end else begin : g_usr
                assign en_w[g] = tc_w[0];
            end
            tick_down_counter #(.DW(DW)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (ld_w[g]),
                .load_val (bus_wdata),
                .cnt_en   (en_w[g]),
                .div_o    (div_w[g]),
                .tc_o     (tc_w[g])
            );
        end
    endgenerate

    tick_timer_regs #(.NT(NT), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .rd_en   (rd_hit),
        .rd_addr (bus_addr),
        .wdata   (bus_wdata),
        .tc      (tc_w[NUM_CNT-1:1]),
        .div_all (div_w),
        .rdata   (bus_rdata),
        .irq     (irq),
        .flag_o  (flag_w),
        .ien_o   (ien_w)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int unsigned NUM_CNT = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [3:0]                 bus_addr,
    input logic [15:0]                bus_rdata,
    input logic                       irq,
    input logic [NUM_CNT-1:0]         tc_w,
    input logic [NUM_CNT-1:0][15:0]   div_w,
    input logic [NUM_CNT-2:0]         flag_w,
    input logic [NUM_CNT-2:0]         ien_w
);

    // R3
    pre_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_w[0] && div_w[0] > 16'd1 && !(bus_sel && bus_wr)) |=> !tc_w[0]);

    // R2
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == 16'h0000));

    // R7
    ctl_spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 4'd7) |=> ((bus_rdata & 16'hF1F1) == 16'h0000));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(flag_w & ien_w)));

    generate
        for (genvar g = 1; g < NUM_CNT; g++) begin : g_usr
            // R4
            usr_needs_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tc_w[g] |-> tc_w[0]);
            // R5
            stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (div_w[g] == 16'h0000) |-> !tc_w[g]);
            // R8
            flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tc_w[g] |=> flag_w[g-1]);
        end
    endgenerate

endmodule

bind tick_timer_bank tick_timer_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tc_w      (tc_w),
    .div_w     (div_w),
    .flag_w    (flag_w),
    .ien_w     (ien_w)
);

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    always #4 clk = ~clk;

    tick_timer_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int          m_div [4];
    int          m_cnt [4];
    bit [2:0]    m_ien;
    bit [2:0]    m_flg;
    bit          m_irq;
    logic [15:0] m_rd;
    int          checks = 0;
    int          errors = 0;
    string       tag = "R10";
    bit          done = 1'b0;

    task automatic check(string r, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rd_val(logic [3:0] a);
        logic [15:0] v;
        v = '0;
        if (a == 4'd7) begin
            v[3:1]  = m_ien;
            v[11:9] = m_flg;
        end else if (a >= 4'd8 && a <= 4'd11) begin
            v = 16'(m_div[a - 4'd8]);
        end
        return v;
    endfunction

    task automatic model_step(bit s, logic [3:0] a, bit w, logic [15:0] d);
        bit tc [4];
        bit pre;
        m_rd  = (s && !w) ? rd_val(a) : 16'h0000;
        m_irq = |(m_flg & m_ien);
        pre   = (m_div[0] != 0) && (m_cnt[0] <= 1);
        for (int i = 0; i < 4; i++) begin
            bit en;
            en    = (i == 0) ? 1'b1 : pre;
            tc[i] = en && (m_div[i] != 0) && (m_cnt[i] <= 1);
            if (s && w && a == 4'(8 + i)) begin
                m_div[i] = int'(d);
                m_cnt[i] = int'(d);
            end else if (tc[i]) begin
                m_cnt[i] = m_div[i];
            end else if (en && m_div[i] != 0) begin
                m_cnt[i] = m_cnt[i] - 1;
            end
        end
        for (int k = 0; k < 3; k++) begin
            bit clr;
            clr = s && w && a == 4'd7 && d[9 + k];
            m_flg[k] = (m_flg[k] && !clr) || tc[k + 1];
            if (s && w && a == 4'd7) m_ien[k] = d[1 + k];
        end
    endtask

    task automatic cyc(bit s, logic [3:0] a, bit w, logic [15:0] d);
        bus_sel = s; bus_addr = a; bus_wr = w; bus_wdata = d;
        @(posedge clk);
        model_step(s, a, w, d);
        @(negedge clk);
        check(tag, bus_rdata, m_rd);
        check(tag, {15'd0, irq}, {15'd0, m_irq});
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        cyc(1'b1, a, 1'b1, d);
    endtask

    task automatic rd(logic [3:0] a);
        cyc(1'b1, a, 1'b0, 16'h0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 1'b0, 16'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int first;
        for (int i = 0; i < 4; i++) begin m_div[i] = 0; m_cnt[i] = 0; end
        m_ien = '0; m_flg = '0; m_irq = 0; m_rd = '0;
        repeat (3) @(negedge clk);
        // R10: reset state at the ports
        check("R10", bus_rdata, 16'h0000);
        check("R10", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R1: every word reads zero after reset
        tag = "R10";
        for (int a = 0; a < 16; a++) rd(4'(a));

        // R1: divisor readback
        tag = "R1";
        wr(4'd9, 16'h0003); wr(4'd10, 16'h0005); wr(4'd11, 16'h0000);
        wr(4'd8, 16'h0004);
        rd(4'd8); check("R1", bus_rdata, 16'h0004);
        rd(4'd9); rd(4'd10); rd(4'd11);
        // R1: unmapped words read zero
        for (int a = 0; a < 7; a++) rd(4'(a));
        for (int a = 12; a < 16; a++) rd(4'(a));

        // R7: enables load from bits 1..3, spare bits zero
        tag = "R7";
        wr(4'd7, 16'hF1FF & ~16'h0E00);
        rd(4'd7); check("R7", bus_rdata & 16'hF1F1, 16'h0000);

        // R3 / R4 / R5: running with t3 stopped, poll status
        tag = "R4";
        for (int i = 0; i < 30; i++) begin idle(3); rd(4'd7); end
        check("R5", bus_rdata & 16'h0800, 16'h0000);

        // R8: writing zeros leaves flags, ones clear selected flag only
        tag = "R8";
        wr(4'd8, 16'h0000);
        idle(2);
        rd(4'd7);
        wr(4'd7, 16'h000E);
        rd(4'd7);
        wr(4'd7, 16'h020E);
        rd(4'd7);
        check("R8", bus_rdata & 16'h0200, 16'h0000);
        // R8: clears every cycle while running, so some collide with expiries
        wr(4'd8, 16'h0001);
        wr(4'd9, 16'h0002);
        for (int i = 0; i < 40; i++) begin wr(4'd7, 16'h0E0E); rd(4'd7); end

        // R5: prescaler stopped keeps all user flags quiet
        tag = "R5";
        wr(4'd8, 16'h0000);
        wr(4'd7, 16'h0E0E);
        idle(40);
        rd(4'd7);
        check("R5", bus_rdata & 16'h0E00, 16'h0000);

        // R6 / R3: divisor write restarts the period, exact divide by N
        tag = "R6";
        wr(4'd9, 16'h0001);
        wr(4'd8, 16'h0005);
        first = 0;
        for (int k = 1; k <= 20; k++) begin
            idle(1);
            if (irq && first == 0) first = k;
        end
        // flag at edge W+5, irq one edge later
        check("R3", 16'(first), 16'd6);

        // R6: rewrite mid-period and keep running
        wr(4'd10, 16'h0003);
        idle(7);
        wr(4'd8, 16'h0007);
        for (int i = 0; i < 20; i++) begin idle(4); rd(4'd7); end

        // R9: dropping enables drops irq a cycle later
        tag = "R9";
        wr(4'd8, 16'h0000);
        wr(4'd7, 16'h0000);
        idle(3);
        check("R9", {15'd0, irq}, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule